// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Programmable Flags

This block buffers words between a write clock domain and an unrelated read clock domain. Storage is a RAM array of `2**ADDR_W` words followed by a read output register. Two presentation modes are available, and the mode pin is captured only while master reset is low. In **standard** mode the reader pulses a read enable and the word appears on the output one read clock later. The two status outputs then mean "not empty" and "not full". In **fall-through** mode the oldest word moves into the output register by itself. The same two status outputs then mean "output word valid" and "input ready". Because the output register holds one word in this mode, capacity grows to depth+1.

Three occupancy flags are driven, all active low: almost-full, almost-empty and half-full. The almost-full and almost-empty thresholds come in as two offset inputs from an outside register block. Master reset clears the pointers and captures the mode. Partial reset clears the pointers and flags but keeps the captured mode. Retransmit rewinds reading to the first word written since the last reset.

Top module: `dualmode_fifo`

## Requirements
- R1: The mode pin (0 = standard, 1 = fall-through) is captured only while `mrst_n` is low. A partial reset leaves the captured mode unchanged, even if the pin has changed.
- R2: Standard mode, `rd_flag`: low when no word is stored, high when at least one word is stored. A read enable updates `rd_data` at the next read clock edge.
- R3: Standard mode, `wr_flag`: low when exactly 2**ADDR_W words are stored, high otherwise.
- R4: In fall-through mode the first word written into an empty FIFO appears on `rd_data` within a few read clocks with no read enable. At that point `rd_flag` goes low, meaning the word is valid.
- R5: In fall-through mode capacity is 2**ADDR_W+1. `wr_flag` stays low (ready) through 2**ADDR_W writes with no reads, and goes high after the next write.
- R6: `paf_n` is low when the stored count is at least capacity minus `full_off`. With no reads this is after depth−m writes in standard mode and depth+1−m writes in fall-through mode.
- R7: `pae_n` is low when the stored count is at most `empty_off`.
- R8: `hf_n` is low when the stored count exceeds half the capacity, rounded down.
- R9: A write while full and a read (standard mode) while empty are dropped. They move no pointer and do not change `rd_data`.
- R10: After a partial reset the FIFO is empty: `rd_flag` shows no data, `wr_flag` shows space, `pae_n` is low and `hf_n` is high.
- R11: A `retx` pulse rewinds reading to the first word written since the last reset. The same words are then read again in the same order.
- R12: Words are read out in the order they were written, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| mrst_n | input | 1 | Master reset, active low, sampled by both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled by both clocks |
| mode_sel | input | 1 | Mode pin: 0 standard, 1 fall-through; captured during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit request, read domain |
| empty_off | input | ADDR_W+1 | Almost-empty threshold n |
| full_off | input | ADDR_W+1 | Almost-full offset m |
| rd_data | output | DATA_W | Output register |
| rd_flag | output | 1 | Standard: high = not empty; fall-through: low = word valid |
| wr_flag | output | 1 | Standard: low = full; fall-through: high = not ready |
| pae_n | output | 1 | Almost empty, active low |
| paf_n | output | 1 | Almost full, active low |
| hf_n | output | 1 | Half full, active low |

## Verification
The hardest state to reach is the fall-through capacity edge, where the 65th word is accepted only because the output register has already taken the first word. Reaching it needs the write pointer to reach the read domain and the refill pointer to come back across the synchroniser. The bench therefore writes the first word alone, lets the flags settle, and then fills word by word, checking the ready flag just before and just after the last slot. A second hard case is a partial reset with the mode pin flipped. It is exposed by writing a single word afterwards and checking which of the two flag meanings `rd_flag` follows.

// File: rtl/dmf_pkg.sv
// Shared types for the dual-mode FIFO.
package dmf_pkg;
    // Presentation mode captured at master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dmf_sync.sv
// Two-flop synchroniser for a Gray-coded pointer.
// Assumes the input changes by at most one bit per source clock,
// except across a reset or a rewind, which happen while traffic is quiet.
module dmf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages into the destination clock.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dmf_wr_side.sv
// Write domain controller: write pointer, mode capture, full / input-ready,
// almost-full and half-full flags.
// Assumes rgray_s (RAM read pointer) and cgray_s (consumed-word pointer) are
// already synchronised into wr_clk.
module dmf_wr_side import dmf_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              mode_pin,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_s,
    input  logic [ADDR_W:0]   cgray_s,
    input  logic [ADDR_W:0]   full_off,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output fifo_mode_e        mode,
    output logic [ADDR_W:0]   count,
    output logic              wr_flag,
    output logic              paf_n,
    output logic              hf_n
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

    logic [PW-1:0] wbin, wnext, rbin_s, cbin_s, ram_used, cap;
    logic [PW:0]   reach;
    logic          full;

    // Gray to binary for both synchronised pointers.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin_s[i] = ^(rgray_s >> i);
            cbin_s[i] = ^(cgray_s >> i);
        end
    end

    // Occupancy, capacity and flag decode.
    always_comb begin
        ram_used = wbin - rbin_s;
        full     = (ram_used == DEPTH_V);
        count    = wbin - cbin_s;
        cap      = (mode == MODE_FWFT) ? DEPTH_V + PW'(1) : DEPTH_V;
        reach    = {1'b0, count} + {1'b0, full_off};
        paf_n    = !(reach >= {1'b0, cap});
        hf_n     = !(count > (cap >> 1));
        wr_flag  = (mode == MODE_FWFT) ? full : !full;
        wr_fire  = wr_en && !full;
        waddr    = wbin[ADDR_W-1:0];
        wnext    = wbin + PW'(1);
    end

    // Mode capture while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) mode <= fifo_mode_e'(mode_pin);
    end

    // Write pointer in binary and Gray form.
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_fire) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end
endmodule

// File: rtl/dmf_rd_side.sv
// Read domain controller: RAM read pointer, consumed-word pointer, output
// register, empty / output-ready, almost-empty flag and retransmit.
// Assumes wgray_s is the write pointer synchronised into rd_clk and ram_q is
// an asynchronous read of the RAM at raddr.
module dmf_rd_side import dmf_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              mode_pin,
    input  logic              rd_en,
    input  logic              retx,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [ADDR_W:0]   empty_off,
    input  logic [DATA_W-1:0] ram_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W:0]   cgray,
    output fifo_mode_e        mode,
    output logic [ADDR_W:0]   count,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              pae_n
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rbin, cbin, wbin_s, rnext, cnext;
    logic          ov, fwft, ram_empty, take, consume;

    // Gray to binary for the synchronised write pointer.
    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    // Transfer decisions and flag decode.
    always_comb begin
        fwft      = (mode == MODE_FWFT);
        ram_empty = (rbin == wbin_s);
        count     = wbin_s - cbin;
        take      = fwft ? (!ram_empty && (!ov || rd_en)) : (rd_en && !ram_empty);
        consume   = fwft ? (rd_en && ov) : take;
        rnext     = rbin + {{(PW-1){1'b0}}, take};
        cnext     = cbin + {{(PW-1){1'b0}}, consume};
        rd_flag   = fwft ? !ov : !ram_empty;
        pae_n     = !(count <= empty_off);
        raddr     = rbin[ADDR_W-1:0];
    end

    // Mode capture while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) mode <= fifo_mode_e'(mode_pin);
    end

    // Pointers, output register and valid bit.
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            rbin    <= '0;
            cbin    <= '0;
            rgray   <= '0;
            cgray   <= '0;
            ov      <= 1'b0;
            rd_data <= '0;
        end else if (retx) begin
            rbin  <= '0;
            cbin  <= '0;
            rgray <= '0;
            cgray <= '0;
            ov    <= 1'b0;
        end else begin
            rbin  <= rnext;
            cbin  <= cnext;
            rgray <= rnext ^ (rnext >> 1);
            cgray <= cnext ^ (cnext >> 1);
            if (take) rd_data <= ram_q;
            ov <= fwft ? (take || (ov && !rd_en)) : 1'b0;
        end
    end
endmodule

// File: rtl/dualmode_fifo.sv
// Dual-clock FIFO with standard and fall-through presentation modes.
// Holds the RAM array and links the two domain controllers through Gray
// pointer synchronisers. Assumes both resets are held for several cycles of
// each clock and that retransmit is issued while writes are quiet.
module dualmode_fifo import dmf_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              mode_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              retx,
    input  logic [ADDR_W:0]   empty_off,
    input  logic [ADDR_W:0]   full_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              pae_n,
    output logic              paf_n,
    output logic              hf_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] ram_q;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray, cgray, wgray_s, rgray_s, cgray_s;
    logic [PW-1:0]     wr_cnt, rd_cnt;
    logic              wr_fire, clr_n;
    fifo_mode_e        mode_w, mode_r;

    assign clr_n = mrst_n && prst_n;
    assign ram_q = mem[raddr];

    // RAM write port.
    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[waddr] <= wr_data;
    end

    // Read-side pointers carried into the write domain.
    logic [PW-1:0] to_wr   [2];
    logic [PW-1:0] from_rd [2];
    assign to_wr[0] = rgray;
    assign to_wr[1] = cgray;
    assign rgray_s  = from_rd[0];
    assign cgray_s  = from_rd[1];

    for (genvar g = 0; g < 2; g++) begin : g_rd2wr
        dmf_sync #(.W(PW)) u_sync (
            .clk(wr_clk), .clr_n(clr_n), .d(to_wr[g]), .q(from_rd[g])
        );
    end

    dmf_sync #(.W(PW)) u_wsync (
        .clk(rd_clk), .clr_n(clr_n), .d(wgray), .q(wgray_s)
    );

    dmf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_pin(mode_sel),
        .wr_en(wr_en), .rgray_s(rgray_s), .cgray_s(cgray_s), .full_off(full_off),
        .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray), .mode(mode_w),
        .count(wr_cnt), .wr_flag(wr_flag), .paf_n(paf_n), .hf_n(hf_n)
    );

    dmf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_pin(mode_sel),
        .rd_en(rd_en), .retx(retx), .wgray_s(wgray_s), .empty_off(empty_off),
        .ram_q(ram_q), .raddr(raddr), .rgray(rgray), .cgray(cgray),
        .mode(mode_r), .count(rd_cnt), .rd_data(rd_data), .rd_flag(rd_flag),
        .pae_n(pae_n)
    );
endmodule

// File: rtl/dmf_checker.sv
// Property checker for dualmode_fifo, attached by bind below.
module dmf_checker import dmf_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mrst_n,
    input logic              prst_n,
    input fifo_mode_e        mode_w,
    input fifo_mode_e        mode_r,
    input logic [ADDR_W:0]   wr_cnt,
    input logic [ADDR_W:0]   rd_cnt,
    input logic              rd_en,
    input logic              rd_flag,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_flag,
    input logic              paf_n,
    input logic              hf_n,
    input logic              pae_n
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

    // R5
    wr_capacity_chk: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
        wr_cnt <= ((mode_w == MODE_FWFT) ? DEPTH_V + PW'(1) : DEPTH_V));

    // R9
    empty_read_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        (mode_r == MODE_STD && rd_en && !rd_flag) |=> $stable(rd_data));

    // R6
    full_implies_flags_chk: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
        (mode_w == MODE_STD && !wr_flag) |-> (!paf_n && !hf_n));

    // R1
    mode_hold_chk: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(mode_w));

    // R7
    empty_pae_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        (rd_cnt == '0) |-> !pae_n);
endmodule

bind dualmode_fifo dmf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dmf_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_w(mode_w), .mode_r(mode_r), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
    .rd_en(rd_en), .rd_flag(rd_flag), .rd_data(rd_data), .wr_flag(wr_flag),
    .paf_n(paf_n), .hf_n(hf_n), .pae_n(pae_n)
);

// File: tb/dualmode_fifo_bench.sv
// Directed bench for dualmode_fifo: one task per scenario.
module dualmode_fifo_bench;
    localparam int ADDR_W = 6;
    localparam int DW     = 9;
    localparam int DEPTH  = 1 << ADDR_W;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [ADDR_W:0] empty_off = 7'd3, full_off = 7'd4;
    logic [DW-1:0] rd_data;
    logic          rd_flag, wr_flag, pae_n, paf_n, hf_n;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit fwft_b = 1'b0;

    dualmode_fifo #(.ADDR_W(ADDR_W), .DATA_W(DW)) u_dualmode_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .retx(retx), .empty_off(empty_off), .full_off(full_off),
        .rd_data(rd_data), .rd_flag(rd_flag), .wr_flag(wr_flag),
        .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n)
    );

    // 50 MHz on both clocks, read clock offset by 7 ns.
    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wr_clk);
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic mreset(input bit m);
        mrst_n = 1'b0; mode_sel = m; fwft_b = m;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        mrst_n = 1'b1;
        settle();
    endtask

    task automatic preset();
        prst_n = 1'b0;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        prst_n = 1'b1;
        settle();
    endtask

    task automatic put(input int v);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = v[DW-1:0];
        @(negedge wr_clk); wr_en = 1'b0;
    endtask

    task automatic get(output int v);
        if (fwft_b) begin
            @(negedge rd_clk); v = int'(rd_data); rd_en = 1'b1;
            @(negedge rd_clk); rd_en = 1'b0;
        end else begin
            @(negedge rd_clk); rd_en = 1'b1;
            @(negedge rd_clk); rd_en = 1'b0; v = int'(rd_data);
        end
    endtask

    task automatic t_reset_state();
        mreset(1'b0);
        chk("R2 empty after reset", int'(rd_flag), 0);
        chk("R3 not full after reset", int'(wr_flag), 1);
        chk("R7 pae after reset", int'(pae_n), 0);
        chk("R6 paf after reset", int'(paf_n), 1);
        chk("R8 hf after reset", int'(hf_n), 1);
    endtask

    task automatic t_std_fill();
        int v, bad;
        mreset(1'b0);
        for (int i = 0; i < 3; i++) put(16 + i);
        settle(); chk("R7 pae at 3 words", int'(pae_n), 0);
        put(19);
        settle(); chk("R7 pae at 4 words", int'(pae_n), 1);
        chk("R2 not empty", int'(rd_flag), 1);
        for (int i = 4; i < 32; i++) put(16 + i);
        settle(); chk("R8 hf at 32 words", int'(hf_n), 1);
        put(16 + 32);
        settle(); chk("R8 hf at 33 words", int'(hf_n), 0);
        for (int i = 33; i < 59; i++) put(16 + i);
        settle(); chk("R6 paf at 59 words", int'(paf_n), 1);
        put(16 + 59);
        settle(); chk("R6 paf at 60 words", int'(paf_n), 0);
        for (int i = 60; i < 63; i++) put(16 + i);
        settle(); chk("R3 full flag at 63 words", int'(wr_flag), 1);
        put(16 + 63);
        settle(); chk("R3 full flag at 64 words", int'(wr_flag), 0);
        put(9'h1FF);
        settle();
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            get(v);
            if (v != 16 + i) bad++;
        end
        chk("R12 standard order mismatches", bad, 0);
        settle();
        chk("R9 overflow word dropped, empty", int'(rd_flag), 0);
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
        settle();
        chk("R9 read on empty keeps rd_data", int'(rd_data), 16 + 63);
        put(9'h055);
        settle(); get(v);
        chk("R9 read pointer unmoved after empty read", v, 9'h055);
    endtask

    task automatic t_fwft();
        int v, bad;
        mreset(1'b1);
        chk("R4 not valid after reset", int'(rd_flag), 1);
        chk("R5 input ready after reset", int'(wr_flag), 0);
        put(9'h040);
        chk("R4 not yet valid right after write", int'(rd_flag), 1);
        settle();
        chk("R4 word valid without read", int'(rd_flag), 0);
        chk("R4 word falls through", int'(rd_data), 9'h040);
        for (int i = 1; i < 60; i++) put(9'h040 + i);
        settle(); chk("R6 fall-through paf at 60", int'(paf_n), 1);
        put(9'h040 + 60);
        settle(); chk("R6 fall-through paf at 61", int'(paf_n), 0);
        for (int i = 61; i < 64; i++) put(9'h040 + i);
        settle(); chk("R5 ready at 64 words", int'(wr_flag), 0);
        put(9'h040 + 64);
        settle(); chk("R5 not ready at 65 words", int'(wr_flag), 1);
        chk("R8 hf at 65 words", int'(hf_n), 0);
        put(9'h1FF);
        settle();
        bad = 0;
        for (int i = 0; i <= DEPTH; i++) begin
            get(v);
            if (v != 9'h040 + i) bad++;
        end
        chk("R12 fall-through order mismatches", bad, 0);
        settle();
        chk("R9 fall-through overflow dropped", int'(rd_flag), 1);
    endtask

    task automatic t_partial();
        int v;
        mreset(1'b0);
        for (int i = 0; i < 5; i++) put(i + 1);
        settle();
        mode_sel = 1'b1;
        preset();
        chk("R10 empty after partial reset", int'(rd_flag), 0);
        chk("R10 space after partial reset", int'(wr_flag), 1);
        chk("R10 pae after partial reset", int'(pae_n), 0);
        chk("R10 hf after partial reset", int'(hf_n), 1);
        put(9'h033);
        settle();
        chk("R1 standard meaning kept", int'(rd_flag), 1);
        get(v);
        chk("R10 fresh word after partial reset", v, 9'h033);
        mode_sel = 1'b0;
    endtask

    task automatic t_retx();
        int v, bad;
        mreset(1'b0);
        for (int i = 0; i < 5; i++) put(9'h100 + i);
        settle();
        for (int i = 0; i < 5; i++) get(v);
        settle();
        chk("R11 empty before rewind", int'(rd_flag), 0);
        @(negedge rd_clk); retx = 1'b1;
        @(negedge rd_clk); retx = 1'b0;
        settle();
        chk("R11 data again after rewind", int'(rd_flag), 1);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            get(v);
            if (v != 9'h100 + i) bad++;
        end
        chk("R11 replay mismatches", bad, 0);
    endtask

    initial begin
        t_reset_state();
        t_std_fill();
        t_fwft();
        t_partial();
        t_retx();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (completion)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule